// File: doc/BRIEF.md
# Event Allow/Deny Filter Table

This block keeps one permission bit for every event number that a bank of event counters could be asked to count. Before the system starts running, a configuration agent issues range commands. Each command carries a base event, a count and an action, either allow or deny. Once the system is running, the counter logic presents an event number on the lookup port and receives, one cycle later, whether counting that event is permitted.

A second, purely combinational port takes two 64-bit event-capability words and returns them masked by the table. The caller then sees only events that are both implemented and permitted. Until any command has been accepted the table is inactive: every lookup is permitted and the capability words pass through unmasked.

The controller is a two-state machine. ST_IDLE waits for commands. The transition IDLE→WALK is taken on an accepted command with a non-zero count. ST_WALK writes one table entry per clock. The transition WALK→IDLE is taken after the last entry of the range is written. An accepted command with a zero count, and every rejected command, stays in ST_IDLE.

Top module: `evt_filter_table`

## Requirements
- R1: After reset, before any command is accepted, every lookup returns allowed and the capability outputs equal the inputs, except for the fixed adjustments of R10.
- R2: The action encoding is 1 = allow and 2 = deny. A command with any other action is rejected with response code 2. Every command produces exactly one response (`resp_valid_o`) on the cycle after it is presented. Response codes are 0 = accepted, 1 = range error, 2 = bad action, 3 = busy.
- R3: A command whose base plus count exceeds the table depth is rejected with code 1. A command whose sum equals the depth exactly is accepted.
- R4: After `run_i` has been high for any clock edge, every later command is rejected with code 3 until the next reset. A command presented while a range walk is in progress is also rejected with code 3. A rejected command leaves the table unchanged.
- R5: The first accepted command initialises the whole table. If its action is allow, every entry is first cleared (default deny). If its action is deny, every entry is first set (default allow). Later commands do not reinitialise the table.
- R6: An accepted allow command sets entries [base, base+count), and a deny command clears them. The writes happen one entry per clock, and `busy_o` is high for exactly `count` cycles, beginning the cycle after the command.
- R7: `lk_ready_o` is low while `busy_o` is high. A lookup held during that time is taken once the walk ends and sees the fully updated table. `lk_valid_o`/`lk_allow_o` appear on the cycle after the lookup is taken.
- R8: Event 0x00 (software increment) and event 0x1E (chain) are always reported as allowed, whatever the table holds.
- R9: Once configured, bits [31:0] of `cap_lo_i` are ANDed with table entries 0–31, and bits [31:0] of `cap_hi_i` with entries 32–63. Bits [63:32] of the two words are ANDed with entries 0x4000–0x401F and 0x4020–0x403F when the depth is at least 0x4040. Otherwise those bits read as zero.
- R10: Bit 30 of `cap_lo_o` (chain event) always reads 1. When `ver_ge34_i` is high, bit 28 of `cap_hi_o` (event 0x3C, stall slot) always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run_i | input | 1 | System-running flag; locks configuration once seen |
| cmd_valid_i | input | 1 | Range command strobe |
| cmd_base_i | input | EVT_BITS+1 | First event number of the range |
| cmd_count_i | input | EVT_BITS+1 | Number of entries in the range |
| cmd_action_i | input | 2 | 1 = allow, 2 = deny |
| resp_valid_o | output | 1 | Response strobe, one cycle after the command |
| resp_code_o | output | 2 | 0 ok, 1 range, 2 action, 3 busy |
| busy_o | output | 1 | Range walk in progress |
| lk_valid_i | input | 1 | Lookup request |
| lk_event_i | input | EVT_BITS | Event number to look up |
| lk_ready_o | output | 1 | Lookup can be taken this cycle |
| lk_valid_o | output | 1 | Lookup result strobe |
| lk_allow_o | output | 1 | Event permitted |
| ver_ge34_i | input | 1 | Counter architecture revision is 3.4 or later |
| cap_lo_i | input | 64 | Capability word for events 0–31 (and extended range) |
| cap_hi_i | input | 64 | Capability word for events 32–63 (and extended range) |
| cap_lo_o | output | 64 | Masked low capability word |
| cap_hi_o | output | 64 | Masked high capability word |

## Verification
The hardest situation to reach from the ports is a lookup that arrives while a range walk is half done. Such a lookup must neither be answered early nor see a partly written table. The bench starts a 20-entry allow walk and raises a lookup on the last entry of that range in the very next cycle. It then counts the cycles during which `lk_ready_o` stays low, and checks that the eventual answer reflects the completed write. A separate directed case sends a second command one cycle into a walk to get the busy rejection. A reset in the middle of the run then allows a deny command to be the first one, which exercises the default-allow initialisation.

// File: rtl/evt_filter_pkg.sv
package evt_filter_pkg;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_ALLOW = 2'd1,
        ACT_DENY  = 2'd2,
        ACT_RSVD  = 2'd3
    } filt_act_e;

    typedef enum logic [1:0] {
        RSP_OK     = 2'd0,
        RSP_RANGE  = 2'd1,
        RSP_ACTION = 2'd2,
        RSP_BUSY   = 2'd3
    } filt_rsp_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } filt_state_e;

    localparam int EV_SWINC   = 'h00;
    localparam int EV_CHAIN   = 'h1E;
    localparam int EV_STALL   = 'h3C;
    localparam int EXT_OFFSET = 'h4000;

endpackage

// File: rtl/evt_filter_ctrl.sv
module evt_filter_ctrl
    import evt_filter_pkg::*;
#(
    parameter int EVT_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                cmd_valid_i,
    input  logic [EVT_BITS:0]   cmd_base_i,
    input  logic [EVT_BITS:0]   cmd_count_i,
    input  logic [1:0]          cmd_action_i,
    output logic                resp_valid_o,
    output logic [1:0]          resp_code_o,
    output logic                busy_o,
    output logic                configured_o,
    output logic                init_o,
    output logic                init_fill_o,
    output logic                wr_en_o,
    output logic [EVT_BITS-1:0] wr_addr_o,
    output logic                wr_val_o
);
    localparam int DEPTH = 1 << EVT_BITS;
    localparam int CW    = EVT_BITS + 1;

    filt_state_e         state_q, state_d;
    logic                locked_q;
    logic                configured_q;
    logic                resp_valid_q;
    filt_rsp_e           resp_code_q;
    logic [EVT_BITS-1:0] ptr_q;
    logic [CW-1:0]       remain_q;
    logic                val_q;

    filt_rsp_e           code;
    logic                accept;
    logic [CW:0]         range_end;

    // Command validation: lock has priority, then action, then range.
    always_comb begin
        range_end = {1'b0, cmd_base_i} + {1'b0, cmd_count_i};
        if (run_i || locked_q || state_q == ST_WALK)
            code = RSP_BUSY;
        else if (cmd_action_i != ACT_ALLOW && cmd_action_i != ACT_DENY)
            code = RSP_ACTION;
        else if (range_end > (CW+1)'(DEPTH))
            code = RSP_RANGE;
        else
            code = RSP_OK;
        accept = cmd_valid_i && (code == RSP_OK);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && cmd_count_i != '0) state_d = ST_WALK;
            ST_WALK: if (remain_q == CW'(1))          state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Walk datapath and response registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q     <= 1'b0;
            configured_q <= 1'b0;
            resp_valid_q <= 1'b0;
            resp_code_q  <= RSP_OK;
            ptr_q        <= '0;
            remain_q     <= '0;
            val_q        <= 1'b0;
        end else begin
            locked_q     <= locked_q | run_i;
            resp_valid_q <= cmd_valid_i;
            resp_code_q  <= code;
            if (accept) begin
                configured_q <= 1'b1;
                ptr_q        <= cmd_base_i[EVT_BITS-1:0];
                remain_q     <= cmd_count_i;
                val_q        <= (cmd_action_i == ACT_ALLOW);
            end else if (state_q == ST_WALK) begin
                ptr_q    <= ptr_q + 1'b1;
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        resp_valid_o = resp_valid_q;
        resp_code_o  = resp_code_q;
        busy_o       = (state_q == ST_WALK);
        configured_o = configured_q;
        init_o       = accept && !configured_q;
        init_fill_o  = (cmd_action_i == ACT_DENY);
        wr_en_o      = (state_q == ST_WALK);
        wr_addr_o    = ptr_q;
        wr_val_o     = val_q;
    end

endmodule

// File: rtl/evt_filter_bitmap.sv
module evt_filter_bitmap
    import evt_filter_pkg::*;
#(
    parameter int EVT_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_i,
    input  logic                init_fill_i,
    input  logic                wr_en_i,
    input  logic [EVT_BITS-1:0] wr_addr_i,
    input  logic                wr_val_i,
    input  logic                configured_i,
    input  logic                lk_fire_i,
    input  logic [EVT_BITS-1:0] lk_event_i,
    output logic                lk_valid_o,
    output logic                lk_allow_o,
    input  logic                ver_ge34_i,
    input  logic [63:0]         cap_lo_i,
    input  logic [63:0]         cap_hi_i,
    output logic [63:0]         cap_lo_o,
    output logic [63:0]         cap_hi_o
);
    localparam int DEPTH = 1 << EVT_BITS;

    logic [DEPTH-1:0] bits_q;
    logic             lk_valid_q;
    logic             lk_allow_q;
    logic             bypass;
    logic [31:0]      ext_lo, ext_hi;
    logic [63:0]      hi_src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bits_q <= '1;
        else if (init_i)  bits_q <= {DEPTH{init_fill_i}};
        else if (wr_en_i) bits_q[wr_addr_i] <= wr_val_i;
    end

    assign bypass = (lk_event_i == EVT_BITS'(EV_SWINC)) ||
                    (lk_event_i == EVT_BITS'(EV_CHAIN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_valid_q <= 1'b0;
            lk_allow_q <= 1'b0;
        end else begin
            lk_valid_q <= lk_fire_i;
            if (lk_fire_i)
                lk_allow_q <= bypass || !configured_i || bits_q[lk_event_i];
        end
    end

    assign lk_valid_o = lk_valid_q;
    assign lk_allow_o = lk_allow_q;

    generate
        if (DEPTH >= EXT_OFFSET + 64) begin : g_ext
            assign ext_lo = bits_q[EXT_OFFSET      +: 32];
            assign ext_hi = bits_q[EXT_OFFSET + 32 +: 32];
        end else begin : g_no_ext
            assign ext_lo = '0;
            assign ext_hi = '0;
        end
    endgenerate

    always_comb begin
        hi_src = cap_hi_i;
        if (ver_ge34_i) hi_src[EV_STALL-32] = 1'b0;
        if (configured_i) begin
            cap_lo_o = cap_lo_i & {ext_lo, bits_q[31:0]};
            cap_hi_o = hi_src   & {ext_hi, bits_q[63:32]};
        end else begin
            cap_lo_o = cap_lo_i;
            cap_hi_o = hi_src;
        end
        cap_lo_o[EV_CHAIN] = 1'b1;
    end

endmodule

// File: rtl/evt_filter_table.sv
module evt_filter_table
    import evt_filter_pkg::*;
#(
    parameter int EVT_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                cmd_valid_i,
    input  logic [EVT_BITS:0]   cmd_base_i,
    input  logic [EVT_BITS:0]   cmd_count_i,
    input  logic [1:0]          cmd_action_i,
    output logic                resp_valid_o,
    output logic [1:0]          resp_code_o,
    output logic                busy_o,
    input  logic                lk_valid_i,
    input  logic [EVT_BITS-1:0] lk_event_i,
    output logic                lk_ready_o,
    output logic                lk_valid_o,
    output logic                lk_allow_o,
    input  logic                ver_ge34_i,
    input  logic [63:0]         cap_lo_i,
    input  logic [63:0]         cap_hi_i,
    output logic [63:0]         cap_lo_o,
    output logic [63:0]         cap_hi_o
);
    logic                configured;
    logic                init, init_fill;
    logic                wr_en, wr_val;
    logic [EVT_BITS-1:0] wr_addr;
    logic                walking;

    evt_filter_ctrl #(.EVT_BITS(EVT_BITS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_i),
        .cmd_valid_i  (cmd_valid_i),
        .cmd_base_i   (cmd_base_i),
        .cmd_count_i  (cmd_count_i),
        .cmd_action_i (cmd_action_i),
        .resp_valid_o (resp_valid_o),
        .resp_code_o  (resp_code_o),
        .busy_o       (walking),
        .configured_o (configured),
        .init_o       (init),
        .init_fill_o  (init_fill),
        .wr_en_o      (wr_en),
        .wr_addr_o    (wr_addr),
        .wr_val_o     (wr_val)
    );

    assign busy_o     = walking;
    assign lk_ready_o = !walking;

    evt_filter_bitmap #(.EVT_BITS(EVT_BITS)) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_i       (init),
        .init_fill_i  (init_fill),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_val_i     (wr_val),
        .configured_i (configured),
        .lk_fire_i    (lk_valid_i && !walking),
        .lk_event_i   (lk_event_i),
        .lk_valid_o   (lk_valid_o),
        .lk_allow_o   (lk_allow_o),
        .ver_ge34_i   (ver_ge34_i),
        .cap_lo_i     (cap_lo_i),
        .cap_hi_i     (cap_hi_i),
        .cap_lo_o     (cap_lo_o),
        .cap_hi_o     (cap_hi_o)
    );

endmodule

// File: rtl/evt_filter_table_chk.sv
module evt_filter_table_chk #(
    parameter int EVT_BITS = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run_i,
    input logic                cmd_valid_i,
    input logic                resp_valid_o,
    input logic [1:0]          resp_code_o,
    input logic                busy_o,
    input logic                lk_valid_i,
    input logic [EVT_BITS-1:0] lk_event_i,
    input logic                lk_valid_o,
    input logic                lk_allow_o
);
    // R2: one response per command, on the following cycle
    a_r2_resp_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o == $past(cmd_valid_i));

    // R4: a command seen with run high is answered busy
    a_r4_run_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && $past(run_i)) |-> resp_code_o == 2'd3);

    // R4: a command seen during a walk is answered busy
    a_r4_walk_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && $past(busy_o)) |-> resp_code_o == 2'd3);

    // R6: a rejected command presented while idle starts no walk
    a_r6_reject_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && resp_code_o != 2'd0 && !$past(busy_o)) |-> !busy_o);

    // R7: a result only follows a lookup taken while idle
    a_r7_no_result_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_o |-> $past(lk_valid_i && !busy_o));

    // R8: software-increment event always passes
    a_r8_bypass_swinc: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid_o && $past(lk_event_i) == '0) |-> lk_allow_o);

endmodule

bind evt_filter_table evt_filter_table_chk #(.EVT_BITS(EVT_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run_i),
    .cmd_valid_i  (cmd_valid_i),
    .resp_valid_o (resp_valid_o),
    .resp_code_o  (resp_code_o),
    .busy_o       (busy_o),
    .lk_valid_i   (lk_valid_i),
    .lk_event_i   (lk_event_i),
    .lk_valid_o   (lk_valid_o),
    .lk_allow_o   (lk_allow_o)
);

// File: tb/evt_filter_table_tb.sv
`timescale 1ns/1ps
module evt_filter_table_tb;
    localparam int EVT_BITS = 10;
    localparam int DEPTH    = 1 << EVT_BITS;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                run_i = 1'b0;
    logic                cmd_valid_i = 1'b0;
    logic [EVT_BITS:0]   cmd_base_i = '0;
    logic [EVT_BITS:0]   cmd_count_i = '0;
    logic [1:0]          cmd_action_i = '0;
    logic                resp_valid_o;
    logic [1:0]          resp_code_o;
    logic                busy_o;
    logic                lk_valid_i = 1'b0;
    logic [EVT_BITS-1:0] lk_event_i = '0;
    logic                lk_ready_o, lk_valid_o, lk_allow_o;
    logic                ver_ge34_i = 1'b0;
    logic [63:0]         cap_lo_i = '0, cap_hi_i = '0;
    logic [63:0]         cap_lo_o, cap_hi_o;

    int checks = 0;
    int fails  = 0;
    bit model [DEPTH];
    bit configured = 0;
    bit locked = 0;

    always #5 clk = ~clk;

    evt_filter_table #(.EVT_BITS(EVT_BITS)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_code(int base, int count, int act);
        if (locked) return 3;
        if (act != 1 && act != 2) return 2;
        if (base + count > DEPTH) return 1;
        return 0;
    endfunction

    function automatic bit exp_allow(int ev);
        return (ev == 0) || (ev == 'h1E) || !configured || model[ev];
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        configured = 0;
        locked = 0;
        for (int i = 0; i < DEPTH; i++) model[i] = 1;
        @(negedge clk);
    endtask

    task automatic send_cmd(input int base, input int count, input int act, input string req);
        int ec, busy_cycles;
        ec = exp_code(base, count, act);
        cmd_valid_i  = 1'b1;
        cmd_base_i   = base[EVT_BITS:0];
        cmd_count_i  = count[EVT_BITS:0];
        cmd_action_i = act[1:0];
        @(negedge clk);
        cmd_valid_i = 1'b0;
        chk(resp_valid_o && resp_code_o == ec[1:0], req, resp_code_o, ec);
        busy_cycles = 0;
        while (busy_o) begin
            busy_cycles++;
            @(negedge clk);
        end
        if (ec == 0) begin
            chk(busy_cycles == count, "R6 busy length", busy_cycles, count);
            if (!configured) begin
                for (int i = 0; i < DEPTH; i++) model[i] = (act == 2);
                configured = 1;
            end
            for (int i = base; i < base + count; i++) model[i] = (act == 1);
        end
    endtask

    task automatic lookup(input int ev, input string req, output int stalls);
        bit rdy;
        stalls = 0;
        lk_valid_i = 1'b1;
        lk_event_i = ev[EVT_BITS-1:0];
        forever begin
            rdy = lk_ready_o;
            @(posedge clk);
            if (rdy) break;
            stalls++;
            @(negedge clk);
        end
        @(negedge clk);
        lk_valid_i = 1'b0;
        chk(lk_valid_o && lk_allow_o == exp_allow(ev), req, lk_allow_o, exp_allow(ev));
    endtask

    task automatic check_cap(input logic [63:0] lo, input logic [63:0] hi, input bit ver, input string req);
        logic [63:0] elo, ehi;
        cap_lo_i = lo; cap_hi_i = hi; ver_ge34_i = ver;
        #1;
        elo = lo; ehi = hi;
        if (ver) ehi[28] = 1'b0;
        if (configured) begin
            for (int i = 0; i < 32; i++) begin
                elo[i] = elo[i] & model[i];
                ehi[i] = ehi[i] & model[32+i];
            end
            elo[63:32] = '0;
            ehi[63:32] = '0;
        end
        elo[30] = 1'b1;
        chk(cap_lo_o == elo, {req, " lo"}, cap_lo_o, elo);
        chk(cap_hi_o == ehi, {req, " hi"}, cap_hi_o, ehi);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int st, ec;
        void'($urandom(32'd20240611));
        do_reset();

        // R1: reset state and unconfigured behaviour
        chk(!resp_valid_o && !busy_o && lk_ready_o, "R1 reset outputs", {resp_valid_o, busy_o, lk_ready_o}, 3'b001);
        check_cap(64'hFFFF_0000_A5A5_0F0F, 64'h1234_5678_FFFF_FFFF, 1'b0, "R1 passthrough");
        check_cap(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R10 stall hidden");
        lookup(500, "R1 unconfigured lookup", st);

        // R2: bad actions leave table unconfigured
        send_cmd(10, 4, 0, "R2 action 0 rejected");
        send_cmd(10, 4, 3, "R2 action 3 rejected");
        lookup(11, "R2 reject no effect", st);

        // R3: out-of-range rejected
        send_cmd(1000, 30, 1, "R3 range rejected");
        check_cap(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, "R3 reject keeps unconfigured");

        // R5/R6: first allow -> default deny
        send_cmd(40, 8, 1, "R5 first allow accepted");
        lookup(39, "R5 default deny", st);
        lookup(40, "R6 allow start", st);
        lookup(47, "R6 allow end", st);
        lookup(48, "R6 past end", st);
        lookup(0, "R8 swinc bypass", st);
        lookup('h1E, "R8 chain bypass", st);
        send_cmd(44, 2, 2, "R5 later deny no reinit");
        lookup(44, "R6 deny clears", st);
        lookup(43, "R5 no reinit", st);
        send_cmd(1000, 24, 1, "R3 exact boundary accepted");
        lookup(1023, "R3 last entry", st);
        send_cmd(5, 0, 2, "R6 zero count");
        check_cap(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R9 masked");

        // R7: lookup during a 20-entry walk stalls and sees final table
        cmd_valid_i = 1'b1; cmd_base_i = 100; cmd_count_i = 20; cmd_action_i = 1;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        chk(resp_code_o == 2'd0, "R6 walk cmd ok", resp_code_o, 0);
        for (int i = 100; i < 120; i++) model[i] = 1;
        lookup(119, "R7 stalled lookup sees update", st);
        chk(st == 20, "R7 stall cycles", st, 20);

        // R4: command during walk rejected busy
        cmd_valid_i = 1'b1; cmd_base_i = 200; cmd_count_i = 10; cmd_action_i = 1;
        @(negedge clk);
        cmd_base_i = 300; cmd_count_i = 5; cmd_action_i = 1;
        chk(resp_code_o == 2'd0, "R6 first ok", resp_code_o, 0);
        @(negedge clk);
        cmd_valid_i = 1'b0;
        chk(resp_valid_o && resp_code_o == 2'd3, "R4 busy during walk", resp_code_o, 3);
        for (int i = 200; i < 210; i++) model[i] = 1;
        while (busy_o) @(negedge clk);
        lookup(301, "R4 busy reject no effect", st);

        // Random mix
        for (int n = 0; n < 40; n++) begin
            send_cmd($urandom_range(0, 1030), $urandom_range(0, 40), $urandom_range(0, 3), "R6 random cmd");
            for (int k = 0; k < 5; k++) lookup($urandom_range(0, DEPTH-1), "R6 random lookup", st);
            lookup($urandom_range(0, 63), "R8 random low lookup", st);
            check_cap({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom_range(0, 1)), "R9 random cap");
        end

        // R5: deny as first command -> default allow
        do_reset();
        send_cmd(5, 3, 2, "R5 first deny accepted");
        lookup(4, "R5 default allow", st);
        lookup(6, "R6 deny range", st);
        check_cap(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R9 after deny");

        // R4: run lock
        run_i = 1'b1;
        @(negedge clk);
        run_i = 1'b0;
        locked = 1;
        send_cmd(6, 1, 1, "R4 locked after run");
        lookup(6, "R4 locked table unchanged", st);
        ec = exp_code(0, 1, 1);
        chk(ec == 3, "R4 lock model", ec, 3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule